// File: doc/BRIEF.md
# Multiphase Clock Bank Skew Generator

This block derives four banks of output clocks from a fast tick clock. The tick clock runs at a multiple of the nominal output frequency, so one tick is one time unit (tU). A free-running phase counter wraps every MF ticks and marks the zero-skew reference phase. A two-letter ternary range code selects MF. Each bank has its own two-letter ternary select code, which places its clock at a signed offset of whole tU from that reference. The outputs of banks 3 and 4 can also be divided by two, divided by four or inverted.

Each ternary letter is carried on two wires, encoded L=00, M=01, H=10; the pattern 11 counts as M. A new range code or bank code is taken up only when the phase counter wraps to zero, so a change never produces a shortened pulse. A test selection bypasses the phase counter and sends a reference input to every output, and the divide and invert choices still apply to it. Both pins of a bank carry the same clock.

Top module: `clk_bank_skew`

## Requirements
- R1: The phase period is 32 ticks for range code L (00), 16 for M (01) and 8 for H (10). After reset is released the phase equals n mod MF, where n counts the rising tick edges since release.
- R2: On banks 1 and 2 the select code (first letter on bits 3:2, second letter on bits 1:0) gives these tU offsets: LL -4, LM -3, LH -2, ML -1, MM 0, MH +1, HL +2, HM +3, HH +4. The output is high while (n - offset) mod MF is below MF/2.
- R3: On bank 3 the codes LM, LH, ML, MM, MH, HL, HM give offsets of -6, -4, -2, 0, +2, +4, +6 tU, with the same high-time rule as R2.
- R4: On bank 3, LL gives a clock at half the phase rate and HH a clock at a quarter of it. The half-rate clock is high while floor(n/MF) is even. The quarter-rate clock is high while floor(n/MF) mod 4 is below 2. Both rise only at phase zero.
- R5: On bank 4, LL gives the half-rate clock of R4 and HH gives the inverse of the zero-offset clock, high while n mod MF is at least MF/2. Its seven middle codes give the offsets of R3.
- R6: A wire pair at 11 in a range or bank code behaves exactly as M.
- R7: A range or select change made mid-period leaves the outputs unchanged until the phase counter wraps to zero. From that wrap on, the outputs follow the new setting.
- R8: When the test code is M or H, every output in offset mode copies refIn, one tick late. The half-rate, quarter-rate and inverted modes are then applied to the rising edges of refIn and no longer to the phase counter.
- R9: While rstN is low at a tick edge, every output is driven low.
- R10: The two pins of each bank always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tU per period |
| rstN | input | 1 | Synchronous active-low reset; loads the codes present |
| rangeSel | input | 2 | Ternary range code choosing MF |
| testSel | input | 2 | Ternary test code; L selects normal operation |
| refIn | input | 1 | Reference level used in bypass |
| bank1Sel | input | 4 | Bank 1 select code |
| bank2Sel | input | 4 | Bank 2 select code |
| bank3Sel | input | 4 | Bank 3 select code |
| bank4Sel | input | 4 | Bank 4 select code |
| bank1Clk | output | OUTS_PER_BANK | Bank 1 clocks |
| bank2Clk | output | OUTS_PER_BANK | Bank 2 clocks |
| bank3Clk | output | OUTS_PER_BANK | Bank 3 clocks |
| bank4Clk | output | OUTS_PER_BANK | Bank 4 clocks |

## Verification
The bench builds the block with its defaults: a maximum MF of 32 and two pins per bank. This makes the three periods 32, 16 and 8 ticks. At the 8-tick period, the ±4 and ±6 offsets wrap across most of the cycle, which exercises the modulo arithmetic where it is tightest. A quarter-rate cycle lasts at most 128 ticks, so every divided pattern can be traced completely within one vector. The range change from 32 to 8 ticks mid-period shows that both the period and the offsets switch together at the wrap.

// File: rtl/clkskew_pkg.sv
package clkskew_pkg;
  localparam int MAX_MF    = 32;
  localparam int CNT_W     = $clog2(MAX_MF);
  localparam int PER_W     = CNT_W + 1;
  localparam int OFF_W     = 5;
  localparam int NUM_BANKS = 4;
  localparam int SEL_W     = 4;
  localparam int FRAME_W   = 2;

  typedef enum logic [1:0] {MODE_SKEW, MODE_DIV2, MODE_DIV4, MODE_INV} bankMode_t;

  typedef struct packed {
    bankMode_t          mode;
    logic [OFF_W-1:0]   offset;   // two's complement tU offset
  } bankCfg_t;

  typedef struct packed {
    logic [CNT_W-1:0]   phase;
    logic [PER_W-1:0]   period;
    logic [FRAME_W-1:0] frame;
    logic               bypass;
    logic               refLvl;
    logic [1:0]         refCnt;
  } phaseStrobe_t;

  function automatic int ternVal(input logic [1:0] t);
    case (t)
      2'b00:   ternVal = 0;
      2'b10:   ternVal = 2;
      default: ternVal = 1;
    endcase
  endfunction

  function automatic logic [PER_W-1:0] mfOf(input logic [1:0] rangeCode);
    case (ternVal(rangeCode))
      0:       mfOf = PER_W'(MAX_MF);
      2:       mfOf = PER_W'(MAX_MF / 4);
      default: mfOf = PER_W'(MAX_MF / 2);
    endcase
  endfunction

  function automatic bankCfg_t decodeBank(input int bankIdx, input logic [SEL_W-1:0] code);
    bankCfg_t r;
    int t;
    t = 3 * ternVal(code[3:2]) + ternVal(code[1:0]);
    r.mode   = MODE_SKEW;
    r.offset = '0;
    if (bankIdx < 2) begin
      r.offset = OFF_W'(t - 4);
    end else if (t == 0) begin
      r.mode = MODE_DIV2;
    end else if (t == 8) begin
      r.mode = (bankIdx == 2) ? MODE_DIV4 : MODE_INV;
    end else begin
      r.offset = OFF_W'(2 * (t - 4));
    end
    return r;
  endfunction
endpackage

// File: rtl/clkskew_ctrl.sv
module clkskew_ctrl
  import clkskew_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [1:0]                        rangeSel,
  input  logic [1:0]                        testSel,
  input  logic                              refIn,
  input  logic [NUM_BANKS-1:0][SEL_W-1:0]   bankSel,
  output phaseStrobe_t                      st,
  output bankCfg_t [NUM_BANKS-1:0]          cfgNext
);
  logic [CNT_W-1:0]          cnt, cntNext;
  logic [PER_W-1:0]          period, periodNext;
  logic [FRAME_W-1:0]        frame, frameNext;
  bankCfg_t [NUM_BANKS-1:0]  cfgQ, decoded;
  logic                      refPrev, refRise;
  logic [1:0]                refCnt, refCntNext;
  logic                      boundary;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) decoded[b] = decodeBank(b, bankSel[b]);
  end

  assign boundary   = ({1'b0, cnt} == (period - 1'b1));
  assign refRise    = refIn & ~refPrev;
  assign refCntNext = refCnt + {1'b0, refRise};

  always_comb begin
    cntNext    = boundary ? '0 : cnt + 1'b1;
    periodNext = boundary ? mfOf(rangeSel) : period;
    frameNext  = boundary ? frame + 1'b1 : frame;
    cfgNext    = boundary ? decoded : cfgQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      period  <= mfOf(rangeSel);
      frame   <= '0;
      cfgQ    <= decoded;
      refPrev <= 1'b0;
      refCnt  <= '0;
    end else begin
      cnt     <= cntNext;
      period  <= periodNext;
      frame   <= frameNext;
      cfgQ    <= cfgNext;
      refPrev <= refIn;
      refCnt  <= refCntNext;
    end
  end

  always_comb begin
    st.phase  = cntNext;
    st.period = periodNext;
    st.frame  = frameNext;
    st.bypass = (testSel != 2'b00);
    st.refLvl = refIn;
    st.refCnt = refCntNext;
  end

  // R1: the counter returns to zero right after the last phase of a period
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> (cnt == '0));
  // R1: elsewhere the counter advances by exactly one tick
  a_r1_step: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R7: period, bank settings and frame hold between wraps
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> ($stable(period) && $stable(cfgQ) && $stable(frame)));
endmodule

// File: rtl/clkskew_datapath.sv
module clkskew_datapath
  import clkskew_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  phaseStrobe_t               st,
  input  bankCfg_t [NUM_BANKS-1:0]   cfgNext,
  output logic [NUM_BANKS-1:0]       bankOut
);
  localparam int DIFF_W = PER_W + 2;

  logic signed [DIFF_W-1:0] phaseExt, perExt, halfExt;
  logic zeroHi;

  assign phaseExt = {{(DIFF_W-CNT_W){1'b0}}, st.phase};
  assign perExt   = {{(DIFF_W-PER_W){1'b0}}, st.period};
  assign halfExt  = perExt >>> 1;
  assign zeroHi   = ({1'b0, st.phase} < (st.period >> 1));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic signed [DIFF_W-1:0] offExt, diff, wrapped;
    logic skewHi, nextVal, qReg;

    assign offExt = {{(DIFF_W-OFF_W){cfgNext[b].offset[OFF_W-1]}}, cfgNext[b].offset};
    assign diff   = phaseExt - offExt;

    always_comb begin
      if (diff[DIFF_W-1])      wrapped = diff + perExt;
      else if (diff >= perExt) wrapped = diff - perExt;
      else                     wrapped = diff;
      skewHi = (wrapped < halfExt);
    end

    if (b < 2) begin : g_plain
      always_comb nextVal = st.bypass ? st.refLvl : skewHi;
    end else begin : g_multi
      always_comb begin
        case (cfgNext[b].mode)
          MODE_DIV2: nextVal = st.bypass ? st.refCnt[0] : ~st.frame[0];
          MODE_DIV4: nextVal = st.bypass ? (st.refCnt[0] ^ st.refCnt[1]) : ~st.frame[1];
          MODE_INV:  nextVal = st.bypass ? ~st.refLvl : ~zeroHi;
          default:   nextVal = st.bypass ? st.refLvl : skewHi;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) qReg <= 1'b0;
      else       qReg <= nextVal;
    end
    assign bankOut[b] = qReg;
  end

  // R4: a divided bank-3 clock rises only at phase zero in normal mode
  a_r4_div_rise_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $rose(bankOut[2]) && !$past(st.bypass) &&
     ($past(cfgNext[2].mode) == MODE_DIV2 || $past(cfgNext[2].mode) == MODE_DIV4))
    |-> ($past(st.phase) == '0));
  // R5: inverted bank 4 is the complement of a zero-offset bank 1
  a_r5_inv_vs_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(st.bypass) && $past(cfgNext[3].mode) == MODE_INV &&
     $past(cfgNext[0].offset) == '0)
    |-> (bankOut[3] != bankOut[0]));
  // R8: in bypass an offset-mode bank copies the reference one tick late
  a_r8_bypass_copy: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(st.bypass)) |-> (bankOut[1] == $past(st.refLvl)));
  // R9: reset drives every output low
  a_r9_reset_low: assert property (@(posedge clk)
    !$past(rstN) |-> (bankOut == '0));
endmodule

// File: rtl/clk_bank_skew.sv
module clk_bank_skew
  import clkskew_pkg::*;
#(
  parameter int OUTS_PER_BANK = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               rangeSel,
  input  logic [1:0]               testSel,
  input  logic                     refIn,
  input  logic [SEL_W-1:0]         bank1Sel,
  input  logic [SEL_W-1:0]         bank2Sel,
  input  logic [SEL_W-1:0]         bank3Sel,
  input  logic [SEL_W-1:0]         bank4Sel,
  output logic [OUTS_PER_BANK-1:0] bank1Clk,
  output logic [OUTS_PER_BANK-1:0] bank2Clk,
  output logic [OUTS_PER_BANK-1:0] bank3Clk,
  output logic [OUTS_PER_BANK-1:0] bank4Clk
);
  phaseStrobe_t                    st;
  bankCfg_t [NUM_BANKS-1:0]        cfgNext;
  logic [NUM_BANKS-1:0]            bankOut;
  logic [NUM_BANKS-1:0][SEL_W-1:0] bankSel;

  assign bankSel = {bank4Sel, bank3Sel, bank2Sel, bank1Sel};

  clkskew_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .testSel(testSel),
    .refIn(refIn), .bankSel(bankSel), .st(st), .cfgNext(cfgNext)
  );

  clkskew_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cfgNext(cfgNext), .bankOut(bankOut)
  );

  assign bank1Clk = {OUTS_PER_BANK{bankOut[0]}};
  assign bank2Clk = {OUTS_PER_BANK{bankOut[1]}};
  assign bank3Clk = {OUTS_PER_BANK{bankOut[2]}};
  assign bank4Clk = {OUTS_PER_BANK{bankOut[3]}};
endmodule

// File: tb/tb_clk_bank_skew.sv
module tb_clk_bank_skew;
  logic clk = 1'b0, rstN = 1'b0, refIn = 1'b0;
  logic [1:0] rangeSel = 2'b00, testSel = 2'b00;
  logic [3:0] sel [4];
  logic [1:0] bank1Clk, bank2Clk, bank3Clk, bank4Clk;
  logic [1:0] outs [4];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;   // 250 MHz

  clk_bank_skew dut (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .testSel(testSel), .refIn(refIn),
    .bank1Sel(sel[0]), .bank2Sel(sel[1]), .bank3Sel(sel[2]), .bank4Sel(sel[3]),
    .bank1Clk(bank1Clk), .bank2Clk(bank2Clk), .bank3Clk(bank3Clk), .bank4Clk(bank4Clk)
  );
  assign outs[0] = bank1Clk;
  assign outs[1] = bank2Clk;
  assign outs[2] = bank3Clk;
  assign outs[3] = bank4Clk;

  // {range, bank1, bank2, bank3, bank4}
  localparam int NVEC = 7;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b00, 4'b0101, 4'b0101, 4'b0101, 4'b0101},
    {2'b00, 4'b0000, 4'b1010, 4'b0001, 4'b1001},
    {2'b01, 4'b0100, 4'b0110, 4'b0000, 4'b0000},
    {2'b10, 4'b0010, 4'b1000, 4'b1010, 4'b1010},
    {2'b11, 4'b1111, 4'b1001, 4'b0110, 4'b0100},
    {2'b10, 4'b0001, 4'b0000, 4'b1000, 4'b0010},
    {2'b01, 4'b0111, 4'b1101, 4'b1011, 4'b0011}
  };

  function automatic logic [1:0] nrm(input logic [1:0] t);
    return (t == 2'b11) ? 2'b01 : t;
  endfunction

  function automatic int mfFor(input logic [1:0] r);
    case (nrm(r))
      2'b00:   return 32;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int baseOff(input logic [3:0] c);
    case ({nrm(c[3:2]), nrm(c[1:0])})
      4'b0000: return -4;
      4'b0001: return -3;
      4'b0010: return -2;
      4'b0100: return -1;
      4'b0110: return 1;
      4'b1000: return 2;
      4'b1001: return 3;
      4'b1010: return 4;
      default: return 0;
    endcase
  endfunction

  // 0 offset, 1 half rate, 2 quarter rate, 3 inverted
  function automatic int modeFor(input int bank, input logic [3:0] c);
    int o;
    o = baseOff(c);
    if (bank < 2) return 0;
    if (o == -4) return 1;
    if (o == 4) return (bank == 2) ? 2 : 3;
    return 0;
  endfunction

  function automatic logic expectBit(input int bank, input logic [3:0] c, input int mf, input int n);
    int off, ph;
    case (modeFor(bank, c))
      1: return ((n / mf) % 2) == 0;
      2: return ((n / mf) % 4) < 2;
      3: return (n % mf) >= mf / 2;
      default: begin
        off = (bank < 2) ? baseOff(c) : 2 * baseOff(c);
        ph = (((n - off) % mf) + mf) % mf;
        return ph < mf / 2;
      end
    endcase
  endfunction

  function automatic string tagFor(input int bank, input logic [3:0] c);
    if (c[3:2] == 2'b11 || c[1:0] == 2'b11) return "R6";
    if (bank < 2) return "R2";
    if (bank == 3) return "R5";
    return (modeFor(bank, c) == 0) ? "R3" : "R4";
  endfunction

  task automatic checkPins(input string tag, input int bank, input logic expBit);
    checks++;
    // R10: both pins must carry the expected value
    if (outs[bank] !== {expBit, expBit}) begin
      fails++;
      $display("FAIL %s bank%0d at %0t: actual %b expected %b", tag, bank + 1, $time,
               outs[bank], {expBit, expBit});
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int b = 0; b < 4; b++) checkPins("R9", b, 1'b0);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic runBypass(input logic [3:0] s3, input logic [3:0] s4);
    int rises;
    logic prev;
    rises = 0;
    prev = 1'b0;
    rangeSel = 2'b00; testSel = 2'b01; refIn = 1'b0;
    sel[0] = 4'b0101; sel[1] = 4'b0001; sel[2] = s3; sel[3] = s4;
    doReset();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      refIn = ((i / 3) % 2) == 1;
      if (refIn && !prev) rises++;
      prev = refIn;
      @(posedge clk);
      #1;
      // R8: offset banks copy the reference, divided and inverted banks follow its edges
      checkPins("R8", 0, refIn);
      checkPins("R8", 1, refIn);
      checkPins("R8", 2, (s3 == 4'b0000) ? logic'(rises % 2) : logic'(((rises % 4) == 1) || ((rises % 4) == 2)));
      checkPins("R8", 3, (s4 == 4'b1010) ? ~refIn : logic'(rises % 2));
    end
    testSel = 2'b00;
    refIn = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL all: watchdog expired, actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] v;
    int mf;
    for (int b = 0; b < 4; b++) sel[b] = 4'b0101;

    // R1 R2 R3 R4 R5 R6 R10: table of settings, each traced for four periods
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      {rangeSel, sel[0], sel[1], sel[2], sel[3]} = v;
      testSel = 2'b00;
      refIn = 1'b0;
      doReset();
      mf = mfFor(rangeSel);
      for (int n = 1; n <= 4 * mf + 2; n++) begin
        @(posedge clk);
        #1;
        for (int b = 0; b < 4; b++)
          checkPins((b == 0) ? "R1" : tagFor(b, sel[b]), b, expectBit(b, sel[b], mf, n));
      end
    end

    // R7: change made mid-period takes effect at the next wrap
    rangeSel = 2'b00;
    for (int b = 0; b < 4; b++) sel[b] = 4'b0101;
    doReset();
    repeat (10) @(posedge clk);
    @(negedge clk);
    rangeSel = 2'b10;
    sel[0] = 4'b1010;
    for (int n = 11; n <= 56; n++) begin
      @(posedge clk);
      #1;
      if (n < 32) begin
        checkPins("R7", 0, expectBit(0, 4'b0101, 32, n));
        checkPins("R7", 1, expectBit(1, 4'b0101, 32, n));
      end else begin
        checkPins("R7", 0, expectBit(0, 4'b1010, 8, n - 32));
        checkPins("R7", 1, expectBit(1, 4'b0101, 8, n - 32));
      end
    end

    // R8: bypass with half rate and inversion, then quarter and half rate
    runBypass(4'b0000, 4'b1010);
    runBypass(4'b1010, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule